// File: doc/BRIEF.md
# Random Word Post-Processing Front-End

This block turns a stream of single raw bits from an external noise source into 32-bit random words for a host. Each raw bit arrives with a strobe. It can pass through a bit-mixing shift register, a bias-removing pair corrector, both stages, or neither, chosen at run time by a 2-bit field in a control register. The surviving bits are shifted into a word register. A status flag tells the host when a complete word is waiting.

The host uses a simple register port: a write strobe, a read strobe, a 2-bit address and a data bus. Reads return data combinationally in the cycle the read strobe is high. The host sets an enable bit before any bit is taken in. It then polls the status flag and fetches the word. Fetching the word drops the flag and starts collection of the next word.

A test bit replaces the noise input with an internal shift-register sequence. This makes every word predictable from reset. The control register reads back exactly as written, so software can save it before a power-down and restore it afterwards.

Top module: `rng_postproc`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0 and the data register reads 0.
- R2: Address 0 is the control register: bits [1:0] select the processing mode, bit 2 is the collection enable and bit 3 is the test bit. It reads back the last value written to those four bits, reads 0 in bits above 3, and changes only on a write to address 0.
- R3: While the enable bit is 0 no bit is taken in: the status flag stays 0 and the data register keeps its value whatever the noise strobe does.
- R4: Mode 0 (raw): each accepted strobed bit is shifted into bit 0 of the data register (older bits move toward the top). The status flag rises at the clock edge that takes in the 32nd bit.
- R5: Mode 1 (mixing): a 32-bit register seeded to 0x00000001 computes f = bit ^ s[31] ^ s[21] ^ s[1] ^ s[0] for each accepted bit. It then becomes {s[30:0], f}, and f is the bit passed on.
- R6: Mode 2 (pair correction): accepted bits are taken in non-overlapping pairs. A pair (first, second) = (0,1) emits 0, a pair (1,0) emits 1, and equal pairs emit nothing.
- R7: Mode 3: bits pass through the mixing stage of R5 first and then through the pair correction of R6.
- R8: With the test bit set, the source bit is bit 31 of an internal 32-bit register seeded to 0x6D2B79F5. One bit is offered every cycle in which bits are accepted, and the register then becomes {t[30:0], t[31]^t[21]^t[1]^t[0]}. The noise input and its strobe are ignored.
- R9: While the status flag is 1, incoming bits are dropped and no stage advances. The data register holds its value and the flag stays 1 until the data register is read.
- R10: Address 1 is the status register, with the flag in bit 0. Address 2 is the data register. A read of address 2 clears the flag at the next edge; a read of address 1 does not.
- R11: Writes to address 1 or address 2 change neither the status flag nor the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| host_wdata | input | WORD_W | Write data |
| host_rdata | output | WORD_W | Read data, combinational from address |
| noise_bit | input | 1 | Raw bit from the noise source |
| noise_stb | input | 1 | Strobe marking noise_bit as a fresh sample |

## Verification
A control write takes effect at the edge that closes its cycle, so the bits offered in that same cycle are still handled under the old setting. An accepted bit that survives the enabled stages reaches the data register at the edge of the cycle in which it is strobed. The flag rises at that same edge for the 32nd bit, and a data read clears it at the edge that closes the read cycle. Read values are combinational, so the bench drives inputs one time unit after a rising edge and samples read data half a unit later. It steps a bit-accurate model of the requirements once per edge, so each expected value is the model state as it stands before that edge.

// File: rtl/rng_pkg.sv
package rng_pkg;
   typedef enum logic [1:0] {
      PP_RAW  = 2'd0,
      PP_MIX  = 2'd1,
      PP_WHT  = 2'd2,
      PP_BOTH = 2'd3
   } pp_mode_t;

   typedef struct packed {
      logic     test;
      logic     en;
      pp_mode_t mode;
   } rng_ctl_t;

   localparam int unsigned CTL_BITS = $bits(rng_ctl_t);

   localparam logic [1:0] ADDR_CTL  = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_DATA = 2'd2;
endpackage

// File: rtl/rng_src_sel.sv
module rng_src_sel #(
   parameter int unsigned         W    = 32,
   parameter logic [W-1:0]        TAPS = 32'h8020_0003,
   parameter logic [W-1:0]        SEED = 32'h6D2B_79F5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic test,
   input  logic adv,
   input  logic noise_bit,
   input  logic noise_stb,
   output logic src_bit,
   output logic src_stb
);
   if (SEED == '0) begin : g_bad_seed
      $error("rng_src_sel: SEED must be nonzero");
   end

   logic [W-1:0] tst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tst_q <= SEED;
      else if (adv) tst_q <= {tst_q[W-2:0], ^(tst_q & TAPS)};
   end

   assign src_bit = test ? tst_q[W-1] : noise_bit;
   assign src_stb = test ? 1'b1       : noise_stb;
endmodule

// File: rtl/rng_mix.sv
module rng_mix #(
   parameter int unsigned  W    = 32,
   parameter logic [W-1:0] TAPS = 32'h8020_0003,
   parameter logic [W-1:0] SEED = 32'h0000_0001
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic in_bit,
   input  logic in_stb,
   output logic out_bit,
   output logic out_stb
);
   if (SEED == '0) begin : g_bad_seed
      $error("rng_mix: SEED must be nonzero");
   end

   logic [W-1:0] mix_q;
   logic         fb;

   assign fb = in_bit ^ (^(mix_q & TAPS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              mix_q <= SEED;
      else if (en && in_stb)   mix_q <= {mix_q[W-2:0], fb};
   end

   assign out_bit = en ? fb : in_bit;
   assign out_stb = in_stb;
endmodule

// File: rtl/rng_whiten.sv
module rng_whiten (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic in_bit,
   input  logic in_stb,
   output logic out_bit,
   output logic out_stb
);
   logic half_q;
   logic first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q  <= 1'b0;
         first_q <= 1'b0;
      end else if (en && in_stb) begin
         if (!half_q) begin
            first_q <= in_bit;
            half_q  <= 1'b1;
         end else begin
            half_q  <= 1'b0;
         end
      end
   end

   assign out_bit = en ? first_q : in_bit;
   assign out_stb = en ? (in_stb & half_q & (first_q ^ in_bit)) : in_stb;
endmodule

// File: rtl/rng_accum.sv
module rng_accum #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_bit,
   input  logic         in_stb,
   input  logic         clr,
   output logic [W-1:0] word,
   output logic         valid
);
   localparam int unsigned CNT_W = $clog2(W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word  <= '0;
         valid <= 1'b0;
         cnt_q <= '0;
      end else if (clr && valid) begin
         valid <= 1'b0;
      end else if (in_stb) begin
         word <= {word[W-2:0], in_bit};
         if (cnt_q == LAST) begin
            cnt_q <= '0;
            valid <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rng_postproc.sv
module rng_postproc
   import rng_pkg::*;
#(
   parameter int unsigned        WORD_W   = 32,
   parameter int unsigned        MIX_W    = 32,
   parameter logic [MIX_W-1:0]   MIX_TAPS = 32'h8020_0003,
   parameter logic [MIX_W-1:0]   MIX_SEED = 32'h0000_0001,
   parameter int unsigned        TST_W    = 32,
   parameter logic [TST_W-1:0]   TST_TAPS = 32'h8020_0003,
   parameter logic [TST_W-1:0]   TST_SEED = 32'h6D2B_79F5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [1:0]        host_addr,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_rdata,
   input  logic              noise_bit,
   input  logic              noise_stb
);
   if (WORD_W < CTL_BITS + 1) begin : g_bad_word
      $error("rng_postproc: WORD_W too small for the control field");
   end
   if (MIX_W < 2 || TST_W < 2) begin : g_bad_lfsr
      $error("rng_postproc: shift registers need at least 2 bits");
   end

   rng_ctl_t          ctl_q;
   logic              en_w;
   logic              accept;
   logic              src_bit, src_stb;
   logic              mix_bit, mix_stb;
   logic              wht_bit, wht_stb;
   logic [WORD_W-1:0] acc_word;
   logic              acc_valid;
   logic              unused_wdata;

   assign unused_wdata = ^host_wdata[WORD_W-1:CTL_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             ctl_q <= '0;
      else if (host_wr && host_addr == ADDR_CTL) ctl_q <= rng_ctl_t'(host_wdata[CTL_BITS-1:0]);
   end

   assign en_w   = ctl_q.en;
   assign accept = ctl_q.en & ~acc_valid;

   rng_src_sel #(.W(TST_W), .TAPS(TST_TAPS), .SEED(TST_SEED)) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .test     (ctl_q.test),
      .adv      (accept & ctl_q.test),
      .noise_bit(noise_bit),
      .noise_stb(noise_stb),
      .src_bit  (src_bit),
      .src_stb  (src_stb)
   );

   rng_mix #(.W(MIX_W), .TAPS(MIX_TAPS), .SEED(MIX_SEED)) u_mix (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ctl_q.mode[0]),
      .in_bit (src_bit),
      .in_stb (src_stb & accept),
      .out_bit(mix_bit),
      .out_stb(mix_stb)
   );

   rng_whiten u_wht (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ctl_q.mode[1]),
      .in_bit (mix_bit),
      .in_stb (mix_stb),
      .out_bit(wht_bit),
      .out_stb(wht_stb)
   );

   rng_accum #(.W(WORD_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .in_bit(wht_bit),
      .in_stb(wht_stb),
      .clr   (host_rd && host_addr == ADDR_DATA),
      .word  (acc_word),
      .valid (acc_valid)
   );

   always_comb begin
      host_rdata = '0;
      case (host_addr)
         ADDR_CTL:  host_rdata[CTL_BITS-1:0] = ctl_q;
         ADDR_STAT: host_rdata[0]            = acc_valid;
         ADDR_DATA: host_rdata               = acc_word;
         default:   host_rdata               = '0;
      endcase
   end
endmodule

// File: rtl/rng_postproc_chk.sv
module rng_postproc_chk #(
   parameter int unsigned WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic              host_rd,
   input logic [1:0]        host_addr,
   input logic [3:0]        ctl_bits,
   input logic              en_q,
   input logic              valid_q,
   input logic [WORD_W-1:0] word_q
);
   AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_wr && host_addr == 2'd0) |=> $stable(ctl_bits)); // R2
   AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> $stable(word_q)); // R3
   AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !(host_rd && host_addr == 2'd2)) |=> valid_q); // R9
   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> $stable(word_q)); // R9
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == 2'd2) |=> !valid_q); // R10
endmodule

bind rng_postproc rng_postproc_chk #(.WORD_W(WORD_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .host_wr  (host_wr),
   .host_rd  (host_rd),
   .host_addr(host_addr),
   .ctl_bits (ctl_q),
   .en_q     (en_w),
   .valid_q  (acc_valid),
   .word_q   (acc_word)
);

// File: tb/sim_rng_postproc.sv
`timescale 1ns/100ps
module sim_rng_postproc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [1:0]  host_addr = 2'd0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        noise_bit = 1'b0, noise_stb = 1'b0;

   int n_chk = 0, n_bad = 0, n_cyc = 0;

   // bench model state
   logic [1:0]  m_mode = 2'd0;
   logic        m_en = 1'b0, m_test = 1'b0;
   logic [31:0] m_mix = 32'h0000_0001;
   logic [31:0] m_tl  = 32'h6D2B_79F5;
   logic        m_half = 1'b0, m_first = 1'b0;
   logic [31:0] m_word = '0;
   int          m_cnt = 0;
   logic        m_valid = 1'b0;
   logic [31:0] nz = 32'h1234_5678;
   int          step_n = 0;

   always #2 clk = ~clk;

   rng_postproc u0 (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .noise_bit(noise_bit), .noise_stb(noise_stb)
   );

   always @(posedge clk) begin
      n_cyc <= n_cyc + 1;
      if (n_cyc > 150000) begin
         n_bad = n_bad + 1;
         n_chk = n_chk + 1;
         $display("FAIL watchdog: run did not finish, act=%0d cycles exp<=150000", n_cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   function automatic logic tfb(input logic [31:0] s);
      return s[31] ^ s[21] ^ s[1] ^ s[0];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
      end
   endtask

   task automatic model_cycle(input logic nb, input logic ns, input logic rd,
                              input logic wr, input logic [1:0] ad, input logic [31:0] wd);
      logic acc, b, s, e, f;
      acc = m_en && !m_valid;
      if (m_test) begin
         b = m_tl[31]; s = 1'b1;
         if (acc) m_tl = {m_tl[30:0], tfb(m_tl)};
      end else begin
         b = nb; s = ns;
      end
      if (rd && ad == 2'd2 && m_valid) begin
         m_valid = 1'b0;
      end else if (acc && s) begin
         if (m_mode[0]) begin
            f = b ^ tfb(m_mix);
            m_mix = {m_mix[30:0], f};
            b = f;
         end
         e = 1'b1;
         if (m_mode[1]) begin
            if (!m_half) begin
               m_first = b; m_half = 1'b1; e = 1'b0;
            end else begin
               m_half = 1'b0; e = (m_first != b); b = m_first;
            end
         end
         if (e) begin
            m_word = {m_word[30:0], b};
            if (m_cnt == 31) begin m_cnt = 0; m_valid = 1'b1; end
            else m_cnt++;
         end
      end
      if (wr && ad == 2'd0) {m_test, m_en, m_mode} = wd[3:0];
   endtask

   // one clock: drive, update model, advance past the edge
   task automatic step(input logic rd, input logic wr, input logic [1:0] ad, input logic [31:0] wd);
      logic nb, ns;
      nz = nz * 32'd1103515245 + 32'd12345;
      nb = nz[16];
      ns = (step_n % 5) != 3;
      step_n++;
      noise_bit = nb; noise_stb = ns;
      host_rd = rd; host_wr = wr; host_addr = ad; host_wdata = wd;
      model_cycle(nb, ns, rd, wr, ad, wd);
      @(posedge clk); #1;
   endtask

   task automatic rd_chk(input logic [1:0] ad, input logic [31:0] exp, input string req);
      host_addr = ad; host_rd = 1'b1; host_wr = 1'b0;
      #0.5;
      check(req, host_rdata, exp);
      step(1'b1, 1'b0, ad, '0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, '0);
   endtask

   task automatic wait_word();
      for (int i = 0; i < 4000 && !m_valid; i++) step(1'b0, 1'b0, 2'd0, '0);
   endtask

   task automatic collect(input logic [3:0] ctl, input int nw, input string req);
      step(1'b0, 1'b1, 2'd0, {28'd0, ctl});
      for (int w = 0; w < nw; w++) begin
         wait_word();
         rd_chk(2'd1, 32'd1, "R10 status read keeps flag");
         idle(3);
         rd_chk(2'd1, 32'd1, "R9 flag held while bits dropped");
         rd_chk(2'd2, m_word, req);
         rd_chk(2'd1, 32'd0, "R10 data read clears flag");
      end
   endtask

   initial begin
      #1;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R1 reset state
      rd_chk(2'd0, 32'd0, "R1 control after reset");
      rd_chk(2'd1, 32'd0, "R1 status after reset");
      rd_chk(2'd2, 32'd0, "R1 data after reset");
      // R2 control readback, enable kept clear
      step(1'b0, 1'b1, 2'd0, 32'hFFFF_FFFB);
      rd_chk(2'd0, 32'h0000_000B, "R2 readback of written bits");
      step(1'b0, 1'b1, 2'd0, 32'h0000_0000);
      rd_chk(2'd0, 32'h0000_0000, "R2 readback after clear");
      // R3 disabled: nothing collected
      idle(60);
      rd_chk(2'd1, 32'd0, "R3 no flag while disabled");
      rd_chk(2'd2, 32'd0, "R3 data unchanged while disabled");
      // R4..R7 each mode, several words
      collect(4'b0100, 3, "R4 raw word");
      collect(4'b0101, 3, "R5 mixed word");
      collect(4'b0110, 3, "R6 corrected word");
      collect(4'b0111, 3, "R7 mixed then corrected word");
      // R11 writes to status/data ignored
      step(1'b0, 1'b1, 2'd0, 32'h0000_0004);
      wait_word();
      step(1'b0, 1'b1, 2'd1, 32'h0000_0000);
      step(1'b0, 1'b1, 2'd2, 32'hA5A5_A5A5);
      rd_chk(2'd1, 32'd1, "R11 status unchanged by write");
      rd_chk(2'd2, m_word, "R11 data unchanged by write");
      // R8 test mode in raw and full chain
      collect(4'b1100, 2, "R8 test raw word");
      collect(4'b1111, 2, "R8 test chained word");
      rd_chk(2'd0, 32'h0000_000F, "R2 control kept through operation");
      // R3 disable mid-word: no completion
      step(1'b0, 1'b1, 2'd0, 32'h0000_0004);
      idle(10);
      step(1'b0, 1'b1, 2'd0, 32'h0000_0000);
      idle(80);
      rd_chk(2'd1, 32'd0, "R3 partial word never flagged when disabled");
      rd_chk(2'd2, m_word, "R3 partial data frozen");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule